// File: doc/BRIEF.md
# Snapshot-Read Event Counter Bank

This block holds a bank of event counters, 20 bits each by default, behind a byte-wide register bus. Every counter has its own increment strobe and sits in its own aligned four-byte window. A counter is wider than the bus, so software needs several accesses to read it. To keep those accesses coherent, the block has a single holding register that all counters share. Reading a counter's low byte returns the live low bits and, in the same access, captures that counter's upper bits into the holding register. The two upper-byte addresses of every counter then return that captured copy.

Counters can be read at any time. Software can preset them, one byte at a time and in any order, but only while the stop-mode input is high. The synchronous reset clears the bus output, the event flags and the holding register. It leaves the counter values untouched, so software keeps track of counts relative to a value it has read or preset. For every counter, the block raises a one-cycle increment flag and a one-cycle wrap flag.

Top module: `evcnt_bank`

## Requirements
- R1: The byte at window offset 0 of every counter reads 0x00.
- R2: A read strobe at window offset 3 returns the counter's live bits 7:0 on `bus_rdata` in the cycle after the strobe.
- R3: A read at offset 3 loads counter bits 19:8 into the shared holding register. A read at offset 1 of any counter returns {4'b0000, held bits 19:16}, and a read at offset 2 of any counter returns held bits 15:8.
- R4: The holding register is zero after reset. Only an offset-3 read changes it, so a counter write leaves it unchanged.
- R5: A write to offset 1, 2 or 3 changes the counter only when `stop_mode` is 1. Offset 1 sets bits 19:16, offset 2 sets bits 15:8 and offset 3 sets bits 7:0. Bytes may be written in any order. When `stop_mode` is 0, writes are ignored.
- R6: Bits 7:4 of an offset-1 read are always zero, and written data bits 7:4 at offset 1 are discarded.
- R7: Reset does not change any counter value.
- R8: Each cycle with `inc[i]` high adds one to counter i, and 0xFFFFF wraps to 0x00000.
- R9: `inc_evt[i]` is high for exactly the cycle after an increment is applied to counter i. `wrap_evt[i]` is high in that same cycle only if the increment wrapped the counter.
- R10: When an increment and an offset-3 read of the same counter fall in the same cycle, the returned low byte and the captured upper bits both show the value before the increment. The increment is applied at that same edge.
- R11: A read of an address outside the bank, and any cycle without a read strobe, leave `bus_rdata` at 0x00 in the next cycle. By default the bank starts at 0x40, and counter i occupies 0x40+4i to 0x43+4i.
- R12: A stop-mode write to offset 1, 2 or 3 of counter i in the same cycle as `inc[i]` updates the written byte, keeps the other bytes and drops the increment, with no event flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high master reset |
| stop_mode | input | 1 | High enables counter writes |
| bus_addr | input | AW (8) | Byte address |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data, valid the cycle after the read strobe |
| inc | input | N (8) | Per-counter increment strobes |
| inc_evt | output | N (8) | Per-counter increment flag |
| wrap_evt | output | N (8) | Per-counter wrap flag |

## Verification
Two pairs of functions can land on the same clock edge. The first pair is a low-byte snapshot read and an increment of the same counter. The bench raises both strobes in one cycle on a counter preset to 0x0FFFF. It then judges the returned low byte and the two captured upper bytes against the pre-increment value, and a later full read against the incremented one. The second pair is a stop-mode byte write and an increment of the same counter. For that case the bench checks that the written byte lands, the other bytes keep their values and no increment flag appears.

// File: rtl/evcnt_pkg.sv
package evcnt_pkg;

  localparam int BYTE_W = 8;
  localparam int LANES  = 4;

  // byte position inside a counter's four-byte window
  typedef enum logic [1:0] {
    LANE_ZERO = 2'd0,
    LANE_HI   = 2'd1,
    LANE_MID  = 2'd2,
    LANE_LO   = 2'd3
  } lane_e;

endpackage

// File: rtl/evcnt_decode.sv
module evcnt_decode
  import evcnt_pkg::*;
#(
  parameter int N     = 8,
  parameter int AW    = 8,
  parameter int BASE  = 8'h40,
  parameter int IDX_W = 3
) (
  input  logic [AW-1:0]    addr,
  output logic             hit,
  output logic [IDX_W-1:0] idx,
  output lane_e            lane
);

  localparam int          SPAN   = N * LANES;
  localparam logic [AW:0] BASE_X = (AW+1)'(BASE);
  localparam logic [AW:0] SPAN_X = (AW+1)'(SPAN);

  logic [AW:0] off;

  always_comb begin
    off  = {1'b0, addr} - BASE_X;
    hit  = !off[AW] && (off < SPAN_X);
    idx  = off[IDX_W+1:2];
    lane = lane_e'(off[1:0]);
  end

endmodule

// File: rtl/evcnt_cell.sv
module evcnt_cell
  import evcnt_pkg::*;
#(
  parameter int W = 20
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         inc,
  input  logic         wr_en,
  input  lane_e        wr_lane,
  input  logic [7:0]   wdata,
  output logic [W-1:0] value,
  output logic         inc_evt,
  output logic         wrap_evt
);

  localparam int HI_W = W - 16;

  logic [W-1:0] cnt_q;
  logic [W-1:0] cnt_d;
  logic         step;

  always_comb begin
    step  = inc && !wr_en;
    cnt_d = cnt_q;
    if (wr_en) begin
      case (wr_lane)
        LANE_HI:  cnt_d[W-1:16] = wdata[HI_W-1:0];
        LANE_MID: cnt_d[15:8]   = wdata;
        LANE_LO:  cnt_d[7:0]    = wdata;
        default:  cnt_d         = cnt_q;
      endcase
    end else if (inc) begin
      cnt_d = cnt_q + W'(1);
    end
  end

  // count state deliberately outside the reset domain
  always_ff @(posedge clk) begin
    cnt_q <= cnt_d;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      inc_evt  <= 1'b0;
      wrap_evt <= 1'b0;
    end else begin
      inc_evt  <= step;
      wrap_evt <= step && (&cnt_q);
    end
  end

  assign value = cnt_q;

endmodule

// File: rtl/evcnt_hold.sv
module evcnt_hold #(
  parameter int HW = 12
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [HW-1:0] din,
  output logic [HW-1:0] q
);

  always_ff @(posedge clk) begin
    if (rst) begin
      q <= '0;
    end else if (load) begin
      q <= din;
    end
  end

endmodule

// File: rtl/evcnt_bank.sv
module evcnt_bank
  import evcnt_pkg::*;
#(
  parameter int N    = 8,
  parameter int W    = 20,
  parameter int AW   = 8,
  parameter int BASE = 8'h40
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          stop_mode,
  input  logic [AW-1:0] bus_addr,
  input  logic          bus_rd,
  input  logic          bus_wr,
  input  logic [7:0]    bus_wdata,
  output logic [7:0]    bus_rdata,
  input  logic [N-1:0]  inc,
  output logic [N-1:0]  inc_evt,
  output logic [N-1:0]  wrap_evt
);

  localparam int IDX_W = (N > 1) ? $clog2(N) : 1;
  localparam int HW    = W - 8;
  localparam int HI_W  = W - 16;

  logic             dec_hit;
  logic [IDX_W-1:0] dec_idx;
  lane_e            dec_lane;
  logic             wr_ok;
  logic             snap_ld;
  logic [W-1:0]     cnt_val [N];
  logic [N*W-1:0]   cnt_flat;
  logic [W-1:0]     sel_val;
  logic [HW-1:0]    hold_q;
  logic [7:0]       rd_next;

  evcnt_decode #(
    .N(N), .AW(AW), .BASE(BASE), .IDX_W(IDX_W)
  ) u_dec (
    .addr (bus_addr),
    .hit  (dec_hit),
    .idx  (dec_idx),
    .lane (dec_lane)
  );

  assign wr_ok = bus_wr && stop_mode && dec_hit && (dec_lane != LANE_ZERO);

  for (genvar i = 0; i < N; i++) begin : g_cnt
    evcnt_cell #(.W(W)) u_cell (
      .clk      (clk),
      .rst      (rst),
      .inc      (inc[i]),
      .wr_en    (wr_ok && (dec_idx == IDX_W'(i))),
      .wr_lane  (dec_lane),
      .wdata    (bus_wdata),
      .value    (cnt_val[i]),
      .inc_evt  (inc_evt[i]),
      .wrap_evt (wrap_evt[i])
    );
    assign cnt_flat[i*W +: W] = cnt_val[i];
  end

  assign sel_val = dec_hit ? cnt_val[dec_idx] : '0;
  assign snap_ld = bus_rd && dec_hit && (dec_lane == LANE_LO);

  evcnt_hold #(.HW(HW)) u_hold (
    .clk  (clk),
    .rst  (rst),
    .load (snap_ld),
    .din  (sel_val[W-1:8]),
    .q    (hold_q)
  );

  always_comb begin
    rd_next = 8'h00;
    if (bus_rd && dec_hit) begin
      case (dec_lane)
        LANE_HI:  rd_next = {{(8-HI_W){1'b0}}, hold_q[HW-1:8]};
        LANE_MID: rd_next = hold_q[7:0];
        LANE_LO:  rd_next = sel_val[7:0];
        default:  rd_next = 8'h00;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= 8'h00;
    end else begin
      bus_rdata <= rd_next;
    end
  end

endmodule

// File: rtl/evcnt_bank_chk.sv
module evcnt_bank_chk #(
  parameter int N    = 8,
  parameter int W    = 20,
  parameter int AW   = 8,
  parameter int BASE = 8'h40
) (
  input logic           clk,
  input logic           rst,
  input logic           stop_mode,
  input logic [AW-1:0]  bus_addr,
  input logic           bus_rd,
  input logic           bus_wr,
  input logic [7:0]     bus_rdata,
  input logic [N-1:0]   inc,
  input logic [N-1:0]   inc_evt,
  input logic [N-1:0]   wrap_evt,
  input logic [W-9:0]   hold_q,
  input logic [N*W-1:0] cnt_flat
);

  localparam int IDX_W = (N > 1) ? $clog2(N) : 1;

  logic [AW:0]      c_off;
  logic             c_hit;
  logic [IDX_W-1:0] c_idx;
  logic [1:0]       c_lane;

  always_comb begin
    c_off  = {1'b0, bus_addr} - (AW+1)'(BASE);
    c_hit  = !c_off[AW] && (c_off < (AW+1)'(N*4));
    c_idx  = c_off[IDX_W+1:2];
    c_lane = c_off[1:0];
  end

  a_r11_idle_zero: assert property (@(posedge clk) disable iff (rst)
    !bus_rd |=> (bus_rdata == 8'h00));

  a_r1_byte0_zero: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && c_hit && c_lane == 2'd0) |=> (bus_rdata == 8'h00));

  a_r6_nibble_zero: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && c_hit && c_lane == 2'd1) |=> (bus_rdata[7:4] == 4'h0));

  a_r3_mid_from_hold: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && c_hit && c_lane == 2'd2) |=> (bus_rdata == $past(hold_q[7:0])));

  a_r4_hold_kept: assert property (@(posedge clk) disable iff (rst)
    !(bus_rd && c_hit && c_lane == 2'd3) |=> $stable(hold_q));

  a_r9_wrap_has_inc: assert property (@(posedge clk) disable iff (rst)
    ((wrap_evt & ~inc_evt) == '0));

  for (genvar i = 0; i < N; i++) begin : g_chk
    logic wr_i;
    assign wr_i = bus_wr && stop_mode && c_hit && (c_idx == IDX_W'(i)) && (c_lane != 2'd0);

    a_r5_idle_stable: assert property (@(posedge clk) disable iff (rst)
      (!inc[i] && !wr_i) |=> $stable(cnt_flat[i*W +: W]));

    a_r8_step_one: assert property (@(posedge clk) disable iff (rst)
      (inc[i] && !wr_i) |=> (cnt_flat[i*W +: W] == W'($past(cnt_flat[i*W +: W]) + W'(1))));

    a_r12_write_blocks_evt: assert property (@(posedge clk) disable iff (rst)
      wr_i |=> !inc_evt[i]);
  end

endmodule

bind evcnt_bank evcnt_bank_chk #(
  .N(N), .W(W), .AW(AW), .BASE(BASE)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .stop_mode (stop_mode),
  .bus_addr  (bus_addr),
  .bus_rd    (bus_rd),
  .bus_wr    (bus_wr),
  .bus_rdata (bus_rdata),
  .inc       (inc),
  .inc_evt   (inc_evt),
  .wrap_evt  (wrap_evt),
  .hold_q    (hold_q),
  .cnt_flat  (cnt_flat)
);

// File: tb/sim_evcnt_bank.sv
`timescale 1ns/1ps
module sim_evcnt_bank;

  localparam int N    = 8;
  localparam int W    = 20;
  localparam int AW   = 8;
  localparam int BASE = 8'h40;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          stop_mode = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic          bus_rd = 1'b0;
  logic          bus_wr = 1'b0;
  logic [7:0]    bus_wdata = '0;
  logic [7:0]    bus_rdata;
  logic [N-1:0]  inc = '0;
  logic [N-1:0]  inc_evt;
  logic [N-1:0]  wrap_evt;

  int n_chk = 0;
  int n_bad = 0;
  logic [W-1:0] model [N];

  always #4 clk = ~clk;

  evcnt_bank #(.N(N), .W(W), .AW(AW), .BASE(BASE)) u0 (
    .clk(clk), .rst(rst), .stop_mode(stop_mode), .bus_addr(bus_addr),
    .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .inc(inc), .inc_evt(inc_evt), .wrap_evt(wrap_evt)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] a_of(input int i, input int lane);
    return 8'(BASE + 4 * i + lane);
  endfunction

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk); bus_addr = a; bus_rd = 1'b1;
    @(negedge clk); bus_rd = 1'b0; d = bus_rdata;
  endtask

  task automatic wr(input int i, input int lane, input logic [7:0] d);
    @(negedge clk); bus_addr = a_of(i, lane); bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk); bus_wr = 1'b0;
    if (stop_mode) begin
      case (lane)
        1: model[i][19:16] = d[3:0];
        2: model[i][15:8]  = d;
        3: model[i][7:0]   = d;
        default: ;
      endcase
    end
  endtask

  task automatic read_cnt(input int i, output logic [W-1:0] v);
    logic [7:0] lo, hi, mid;
    rd(a_of(i, 3), lo);
    rd(a_of(i, 1), hi);
    rd(a_of(i, 2), mid);
    chk("R6 offset-1 upper nibble", 32'(hi[7:4]), 32'h0);
    v = {hi[3:0], mid, lo};
  endtask

  task automatic bump(input logic [N-1:0] m);
    logic [N-1:0] wexp;
    wexp = '0;
    @(negedge clk); inc = m;
    @(negedge clk); inc = '0;
    for (int i = 0; i < N; i++) begin
      if (m[i]) begin
        if (model[i] == '1) wexp[i] = 1'b1;
        model[i] = model[i] + W'(1);
      end
    end
    chk("R9 inc_evt", 32'(inc_evt), 32'(m));
    chk("R9 wrap_evt", 32'(wrap_evt), 32'(wexp));
  endtask

  task automatic check_all(input string req);
    logic [W-1:0] v;
    for (int i = 0; i < N; i++) begin
      read_cnt(i, v);
      chk(req, 32'(v), 32'(model[i]));
    end
  endtask

  task automatic preset(input int i, input logic [W-1:0] v);
    wr(i, 1, {4'hA, v[19:16]});
    wr(i, 2, v[15:8]);
    wr(i, 3, v[7:0]);
  endtask

  initial begin
    logic [7:0] d;
    logic [W-1:0] v;

    // reset state
    repeat (3) @(negedge clk);
    chk("R11 rdata in reset", 32'(bus_rdata), 32'h0);
    chk("R9 inc_evt in reset", 32'(inc_evt), 32'h0);
    rst = 1'b0;
    rd(a_of(0, 2), d); chk("R4 hold after reset mid", 32'(d), 32'h0);
    rd(a_of(5, 1), d); chk("R4 hold after reset hi", 32'(d), 32'h0);

    // R5: stop-mode presets, byte order varied per counter
    stop_mode = 1'b1;
    for (int i = 0; i < N; i++) begin
      v = W'(32'h13579 * (i + 1) + i);
      if (i % 2 == 0) begin
        wr(i, 3, v[7:0]); wr(i, 2, v[15:8]); wr(i, 1, {4'h0, v[19:16]});
      end else begin
        wr(i, 1, {4'h0, v[19:16]}); wr(i, 3, v[7:0]); wr(i, 2, v[15:8]);
      end
    end
    stop_mode = 1'b0;
    check_all("R2/R3/R5 preset readback");

    // R1: offset 0 of every counter, R11: addresses outside the bank
    for (int i = 0; i < N; i++) begin
      rd(a_of(i, 0), d); chk("R1 offset-0 zero", 32'(d), 32'h0);
    end
    rd(8'h00, d); chk("R11 unmapped 0x00", 32'(d), 32'h0);
    rd(8'h3F, d); chk("R11 unmapped 0x3F", 32'(d), 32'h0);
    rd(8'h60, d); chk("R11 unmapped 0x60", 32'(d), 32'h0);
    rd(8'hFF, d); chk("R11 unmapped 0xFF", 32'(d), 32'h0);

    // R5: writes outside stop mode ignored
    wr(3, 1, 8'h0E); wr(3, 2, 8'hAB); wr(3, 3, 8'hCD);
    read_cnt(3, v); chk("R5 non-stop write ignored", 32'(v), 32'(model[3]));

    // R6: upper nibble of written data discarded
    stop_mode = 1'b1;
    wr(2, 1, 8'hF7);
    stop_mode = 1'b0;
    rd(a_of(2, 3), d);
    rd(a_of(2, 1), d); chk("R6 hi read masked", 32'(d), 32'h07);

    // R3: shared hold, R4: write leaves hold alone
    rd(a_of(1, 3), d); chk("R2 live low byte", 32'(d), 32'(model[1][7:0]));
    rd(a_of(5, 1), d); chk("R3 shared hold hi", 32'(d), 32'(model[1][19:16]));
    rd(a_of(7, 2), d); chk("R3 shared hold mid", 32'(d), 32'(model[1][15:8]));
    v = model[1];
    stop_mode = 1'b1;
    wr(1, 2, 8'h00); wr(1, 1, 8'h00);
    stop_mode = 1'b0;
    rd(a_of(1, 2), d); chk("R4 hold unchanged by write", 32'(d), 32'(v[15:8]));
    rd(a_of(1, 1), d); chk("R4 hold unchanged by write hi", 32'(d), 32'(v[19:16]));

    // R8/R9: sweep every increment mask
    for (int m = 0; m < 256; m++) bump(8'(m));
    check_all("R8 after mask sweep");

    // R8/R9: wrap on half the counters
    stop_mode = 1'b1;
    for (int i = 0; i < N; i++) preset(i, (i % 2 == 0) ? 20'hFFFFE : 20'h7FFFF);
    stop_mode = 1'b0;
    bump('1);
    bump('1);
    bump('1);
    check_all("R8 wrap to zero");

    // R10: increment coincident with snapshot read
    stop_mode = 1'b1;
    preset(6, 20'h0FFFF);
    stop_mode = 1'b0;
    @(negedge clk); bus_addr = a_of(6, 3); bus_rd = 1'b1; inc = 8'h40;
    @(negedge clk); bus_rd = 1'b0; inc = '0; d = bus_rdata;
    chk("R10 low byte pre-increment", 32'(d), 32'hFF);
    chk("R10 inc_evt", 32'(inc_evt), 32'h40);
    model[6] = model[6] + W'(1);
    rd(a_of(6, 1), d); chk("R10 held hi pre-increment", 32'(d), 32'h00);
    rd(a_of(6, 2), d); chk("R10 held mid pre-increment", 32'(d), 32'hFF);
    read_cnt(6, v); chk("R10 increment applied", 32'(v), 32'h10000);

    // R12: write and increment in one cycle
    stop_mode = 1'b1;
    @(negedge clk); bus_addr = a_of(7, 3); bus_wdata = 8'h55; bus_wr = 1'b1; inc = 8'h80;
    @(negedge clk); bus_wr = 1'b0; inc = '0;
    chk("R12 no inc_evt on write", 32'(inc_evt), 32'h0);
    model[7][7:0] = 8'h55;
    stop_mode = 1'b0;
    read_cnt(7, v); chk("R12 write wins", 32'(v), 32'(model[7]));

    // R7: reset keeps counters
    @(negedge clk); rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    rd(a_of(4, 2), d); chk("R4 hold cleared by reset", 32'(d), 32'h0);
    check_all("R7 counters survive reset");

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule